// File: doc/BRIEF.md
# Indirect-Window Interrupt Routing Register File

This block holds the routing configuration for a bank of interrupt inputs behind a two-location indirect window on a 32-bit memory-mapped bus. Software first writes a register index to the select location at bus offset 0. It then reads or writes the chosen register through the data location at bus offset 16. The registers behind the window are an identifier, a read-only version word, an arbitration identifier and a table with one 64-bit routing entry per interrupt input. Each entry is reached as two 32-bit halves.

The bus uses a single-cycle strobe. `bus_wr` or `bus_rd` is high for one clock, and `bus_be` must show a full 32-bit access. Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. The delivery logic does not read the table through the bus. It sees every entry's fields at once on flat decoded outputs, where entry `k` occupies slice `k` of each vector. Any malformed access sets a sticky error flag that only reset clears. The configured initial identifier must be below 0xFF.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select index is 0, both identifiers equal `INIT_ID`, every entry has mask bit 16 set with all other bits zero, `err_flag` is 0 and `bus_rdata` is 0.
- R2: A write at bus offset 0 stores `bus_wdata[7:0]` as the select index. A read at offset 0 returns the index zero-extended to 32 bits.
- R3: A read strobe is answered on `bus_rdata` in the next cycle. The value stays there until the next read strobe.
- R4: Index 0 is the identifier. Writes take `bus_wdata[31:24]`, and reads return the identifier in bits 31:24 with zeros below.
- R5: Index 1 reads `((NUM_ENTRIES-1) << 16) | VERSION_CODE`. Writes to it change nothing and are not errors.
- R6: Index 2 is the arbitration identifier and behaves like index 0: the value sits in bits 31:24.
- R7: An index `0x10 + 2k` selects the low half of entry `k`, and `0x11 + 2k` selects its high half, for `k` below `NUM_ENTRIES`. A write changes only that half.
- R8: A write to a low half keeps bits 7:0, 10:8, 11, 13, 15 and 16 (mask `0x0001AFFF`) and zeroes the rest. A write to a high half keeps only bits 31:24.
- R9: The decoded outputs of entry `k` show its vector (bits 7:0), delivery mode (10:8), destination mode (11), polarity (13), trigger mode (15), mask (16) and destination (high-half bits 31:24).
- R10: Each of the following is an error: a strobe whose `bus_be` is not `4'hF`, an offset other than 0 or 16, a strobe with both read and write high, or a data access to an index that is undefined (3 to 0x0F, or 0x10 + 2·`NUM_ENTRIES` and above). An error sets the sticky `err_flag`, changes no register, and makes an errored read return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_be | input | 4 | Byte enables; must be all ones |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_flag | output | 1 | Sticky access-error flag |
| id_out | output | 8 | Current identifier |
| arb_out | output | 8 | Current arbitration identifier |
| ent_vector | output | 8·NUM_ENTRIES | Vector field of every entry |
| ent_dlv_mode | output | 3·NUM_ENTRIES | Delivery-mode field of every entry |
| ent_dest_mode | output | NUM_ENTRIES | Destination-mode bit of every entry |
| ent_polarity | output | NUM_ENTRIES | Polarity bit of every entry |
| ent_trigger | output | NUM_ENTRIES | Trigger-mode bit of every entry |
| ent_mask | output | NUM_ENTRIES | Mask bit of every entry |
| ent_dest | output | 8·NUM_ENTRIES | Destination field of every entry |

## Verification
Random writes spread over all index classes carry all-ones and random data. Each is followed by a read-back, which tells the correct reserved-bit scrub apart from a store of the raw data or a mix-up of the two halves. Random reads of undefined indices, including the first index past the table and the gap from 3 to 0x0F, check where the table ends against where the error flag and zero read data begin. Directed cases cover writes to the version word, bad byte enables, a bad offset, and read and write together. Each is followed by a read of the register it could have changed. A full sweep of the decoded outputs against a model confirms that each field comes from the correct entry slice.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Bits of each half that survive a write.
  localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
  localparam logic [31:0] LO_RESET = 32'h0001_0000;

  typedef enum logic [2:0] {
    K_ID,
    K_VER,
    K_ARB,
    K_TAB,
    K_NONE
  } reg_kind_e;

  function automatic logic [31:0] scrub_half(input logic [31:0] d, input logic hi);
    return d & (hi ? HI_KEEP : LO_KEEP);
  endfunction

  function automatic logic [31:0] version_word(input int unsigned n, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(n - 1);
    return {8'h00, top, 8'h00, code};
  endfunction

  function automatic logic [31:0] id_word(input logic [7:0] v);
    return {v, 24'h000000};
  endfunction

endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 5,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        sel,
  output logic              ev_sel_wr,
  output logic              ev_sel_rd,
  output logic              ev_dat_wr,
  output logic              ev_dat_rd,
  output logic              ev_err,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  tab_idx,
  output logic              tab_hi
);

  localparam int TAB_BASE = 16;
  localparam int TAB_END  = TAB_BASE + 2 * NUM_ENTRIES;

  logic       acc, shape_ok, at_sel, at_dat, bad;
  logic [7:0] tab_off;

  always_comb begin
    if (int'(sel) == 0)             kind = K_ID;
    else if (int'(sel) == 1)        kind = K_VER;
    else if (int'(sel) == 2)        kind = K_ARB;
    else if (int'(sel) >= TAB_BASE && int'(sel) < TAB_END) kind = K_TAB;
    else                            kind = K_NONE;
  end

  assign tab_off  = sel - 8'(TAB_BASE);
  assign tab_idx  = tab_off[IDX_W:1];
  assign tab_hi   = tab_off[0];

  assign acc      = wr | rd;
  assign shape_ok = (be == 4'hF) && !(wr && rd);
  assign at_sel   = (addr == ADDR_W'(0));
  assign at_dat   = (addr == ADDR_W'(TAB_BASE));
  assign bad      = acc && (!shape_ok || !(at_sel || at_dat) || (at_dat && kind == K_NONE));

  assign ev_err    = bad;
  assign ev_sel_wr = wr && at_sel && !bad;
  assign ev_sel_rd = rd && at_sel && !bad;
  assign ev_dat_wr = wr && at_dat && !bad;
  assign ev_dat_rd = rd && at_dat && !bad;

  // R10
  ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_sel_wr, ev_sel_rd, ev_dat_wr, ev_dat_rd, ev_err}));

  // R10
  be_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && be != 4'hF) |-> ev_err);

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [31:0] lo_word,
  output logic [31:0] hi_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_word <= LO_RESET;
      hi_word <= '0;
    end else begin
      if (wr_lo) lo_word <= scrub_half(wdata, 1'b0);
      if (wr_hi) hi_word <= scrub_half(wdata, 1'b1);
    end
  end

  // R7
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> ($stable(lo_word) && $stable(hi_word)));

  // R7
  half_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(hi_word));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_ENTRIES  = 24,
  parameter int         ADDR_W       = 5,
  parameter logic [7:0] INIT_ID      = 8'h05,
  parameter logic [7:0] VERSION_CODE = 8'h20,
  localparam int        IDX_W        = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [3:0]               bus_be,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     err_flag,
  output logic [7:0]               id_out,
  output logic [7:0]               arb_out,
  output logic [8*NUM_ENTRIES-1:0] ent_vector,
  output logic [3*NUM_ENTRIES-1:0] ent_dlv_mode,
  output logic [NUM_ENTRIES-1:0]   ent_dest_mode,
  output logic [NUM_ENTRIES-1:0]   ent_polarity,
  output logic [NUM_ENTRIES-1:0]   ent_trigger,
  output logic [NUM_ENTRIES-1:0]   ent_mask,
  output logic [8*NUM_ENTRIES-1:0] ent_dest
);

  localparam logic [31:0] VER_WORD = version_word(NUM_ENTRIES, VERSION_CODE);

  logic [7:0]       sel_q, id_q, arb_q;
  logic             err_q;
  logic [31:0]      rdata_q, rd_mux;
  logic             ev_sel_wr, ev_sel_rd, ev_dat_wr, ev_dat_rd, ev_err;
  reg_kind_e        kind;
  logic [IDX_W-1:0] tab_idx;
  logic             tab_hi;
  logic [31:0]      lo_w [NUM_ENTRIES];
  logic [31:0]      hi_w [NUM_ENTRIES];

  irq_win_decode #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .addr(bus_addr), .be(bus_be), .wr(bus_wr), .rd(bus_rd), .sel(sel_q),
    .ev_sel_wr(ev_sel_wr), .ev_sel_rd(ev_sel_rd),
    .ev_dat_wr(ev_dat_wr), .ev_dat_rd(ev_dat_rd), .ev_err(ev_err),
    .kind(kind), .tab_idx(tab_idx), .tab_hi(tab_hi)
  );

  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      logic hit;
      assign hit = ev_dat_wr && (kind == K_TAB) && (int'(tab_idx) == g);
      irq_redir_entry u_ent (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(hit && !tab_hi), .wr_hi(hit && tab_hi), .wdata(bus_wdata),
        .lo_word(lo_w[g]), .hi_word(hi_w[g])
      );
      assign ent_vector[g*8 +: 8]   = lo_w[g][7:0];
      assign ent_dlv_mode[g*3 +: 3] = lo_w[g][10:8];
      assign ent_dest_mode[g]       = lo_w[g][11];
      assign ent_polarity[g]        = lo_w[g][13];
      assign ent_trigger[g]         = lo_w[g][15];
      assign ent_mask[g]            = lo_w[g][16];
      assign ent_dest[g*8 +: 8]     = hi_w[g][31:24];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      K_ID:    rd_mux = id_word(id_q);
      K_VER:   rd_mux = VER_WORD;
      K_ARB:   rd_mux = id_word(arb_q);
      K_TAB:   rd_mux = tab_hi ? hi_w[tab_idx] : lo_w[tab_idx];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      id_q    <= INIT_ID;
      arb_q   <= INIT_ID;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ev_err) err_q <= 1'b1;
      if (ev_sel_wr) sel_q <= bus_wdata[7:0];
      if (ev_dat_wr && kind == K_ID)  id_q  <= bus_wdata[31:24];
      if (ev_dat_wr && kind == K_ARB) arb_q <= bus_wdata[31:24];
      if (ev_sel_rd)               rdata_q <= {24'h000000, sel_q};
      else if (ev_dat_rd)          rdata_q <= rd_mux;
      else if (bus_rd && ev_err)   rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign err_flag  = err_q;
  assign id_out    = id_q;
  assign arb_out   = arb_q;

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_wr |=> (sel_q == $past(bus_wdata[7:0])));

  // R4
  id_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_wr && kind == K_ID) |=> (id_out == $past(bus_wdata[31:24])));

  // R5
  ver_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_rd && kind == K_VER) |=> (bus_rdata == VER_WORD));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R10
  err_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> ($stable(sel_q) && $stable(id_out) && $stable(arb_out)));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_irq_route_regs.sv
`timescale 1ns/1ps
module tb_irq_route_regs;
  localparam int         N    = 24;
  localparam int         AW   = 5;
  localparam logic [7:0] IID  = 8'h05;
  localparam logic [7:0] VCOD = 8'h20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [3:0]      bus_be = 4'hF;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            err_flag;
  logic [7:0]      id_out, arb_out;
  logic [8*N-1:0]  ent_vector, ent_dest;
  logic [3*N-1:0]  ent_dlv_mode;
  logic [N-1:0]    ent_dest_mode, ent_polarity, ent_trigger, ent_mask;

  int tests = 0, fails = 0;
  logic [7:0]  sel_m, id_m, arb_m;
  logic        err_m;
  logic [31:0] lo_m [N];
  logic [31:0] hi_m [N];

  always #2.5 clk = ~clk;

  irq_route_regs #(.NUM_ENTRIES(N), .ADDR_W(AW), .INIT_ID(IID), .VERSION_CODE(VCOD)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_flag(err_flag), .id_out(id_out), .arb_out(arb_out),
    .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode), .ent_dest_mode(ent_dest_mode),
    .ent_polarity(ent_polarity), .ent_trigger(ent_trigger), .ent_mask(ent_mask),
    .ent_dest(ent_dest)
  );

  // Bench restatement of the kept-bit layout, built field by field.
  function automatic logic [31:0] keep_lo();
    logic [31:0] m = '0;
    m[7:0] = '1; m[10:8] = '1; m[11] = 1'b1; m[13] = 1'b1; m[15] = 1'b1; m[16] = 1'b1;
    return m;
  endfunction

  function automatic bit defined_idx(input logic [7:0] s);
    return (s <= 8'd2) || (s >= 8'h10 && int'(s) < 16 + 2*N);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] s);
    if (s == 8'd0) return {id_m, 24'h0};
    if (s == 8'd1) return (32'(N - 1) << 16) | 32'(VCOD);
    if (s == 8'd2) return {arb_m, 24'h0};
    if (defined_idx(s)) begin
      int k = (int'(s) - 16) / 2;
      return s[0] ? hi_m[k] : lo_m[k];
    end
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic model_data_write(input logic [31:0] d);
    if (sel_m == 8'd0) id_m = d[31:24];
    else if (sel_m == 8'd2) arb_m = d[31:24];
    else if (sel_m == 8'd1) ;
    else if (defined_idx(sel_m)) begin
      int k = (int'(sel_m) - 16) / 2;
      if (sel_m[0]) hi_m[k] = {d[31:24], 24'h0};
      else          lo_m[k] = d & keep_lo();
    end else err_m = 1'b1;
  endtask

  task automatic check_fields();
    for (int k = 0; k < N; k++) begin
      check("R9 vector", 32'(ent_vector[k*8 +: 8]), 32'(lo_m[k][7:0]));
      check("R9 mode",   32'(ent_dlv_mode[k*3 +: 3]), 32'(lo_m[k][10:8]));
      check("R9 bits",   {28'h0, ent_mask[k], ent_trigger[k], ent_polarity[k], ent_dest_mode[k]},
                         {28'h0, lo_m[k][16], lo_m[k][15], lo_m[k][13], lo_m[k][11]});
      check("R9 dest",   32'(ent_dest[k*8 +: 8]), 32'(hi_m[k][31:24]));
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    sel_m = 0; id_m = IID; arb_m = IID; err_m = 0;
    for (int k = 0; k < N; k++) begin lo_m[k] = 32'h0001_0000; hi_m[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 err", 32'(err_flag), 32'h0);
    check("R1 ids", {16'h0, id_out, arb_out}, {16'h0, IID, IID});
    check_fields();

    // R2 select readback
    bus_write(0, 32'hABCD_0011); sel_m = 8'h11;
    bus_read(0, r); check("R2 select", r, 32'h11);
    // R3 hold after read
    repeat (3) @(negedge clk);
    check("R3 hold", bus_rdata, 32'h11);

    // R5 version read and write ignored
    bus_write(0, 32'h1); sel_m = 1;
    bus_read(16, r); check("R5 version", r, model_read(1));
    bus_write(16, 32'hFFFF_FFFF);
    bus_read(16, r); check("R5 write ignored", r, model_read(1));
    check("R5 no error", 32'(err_flag), 32'h0);

    // R4 / R6 identifiers
    bus_write(0, 32'h0); sel_m = 0;
    bus_write(16, 32'h9A12_3456); id_m = 8'h9A;
    bus_read(16, r); check("R4 id", r, 32'h9A00_0000);
    bus_write(0, 32'h2); sel_m = 2;
    bus_write(16, 32'h3CFF_FFFF); arb_m = 8'h3C;
    bus_read(16, r); check("R6 arb", r, 32'h3C00_0000);
    check("R4 R6 ports", {16'h0, id_out, arb_out}, 32'h9A3C);

    // R7 R8 directed: all ones into last entry both halves
    bus_write(0, 32'(16 + 2*(N-1))); sel_m = 8'(16 + 2*(N-1));
    bus_write(16, 32'hFFFF_FFFF); model_data_write(32'hFFFF_FFFF);
    bus_read(16, r); check("R8 low scrub", r, keep_lo());
    bus_write(0, 32'(17 + 2*(N-1))); sel_m = 8'(17 + 2*(N-1));
    bus_write(16, 32'hFFFF_FFFF); model_data_write(32'hFFFF_FFFF);
    bus_read(16, r); check("R8 high scrub", r, 32'hFF00_0000);
    bus_write(0, 32'(16 + 2*(N-2))); sel_m = 8'(16 + 2*(N-2));
    bus_read(16, r); check("R7 neighbour untouched", r, 32'h0001_0000);

    // R10 directed errors
    check("R10 clean before", 32'(err_flag), 32'h0);
    bus_write(0, 32'h77, 4'h3);
    bus_read(0, r); check("R10 be write ignored", r, 32'(sel_m));
    check("R10 flag set", 32'(err_flag), 32'h1); err_m = 1;
    @(negedge clk); bus_addr = 5'd4; bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0;
    check("R10 bad offset reads 0", bus_rdata, 32'h0);
    @(negedge clk); bus_addr = 0; bus_wdata = 32'h5; bus_wr = 1; bus_rd = 1;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    check("R10 rd+wr reads 0", bus_rdata, 32'h0);
    bus_read(0, r); check("R10 rd+wr no write", r, 32'(sel_m));
    bus_write(0, 32'(16 + 2*N)); sel_m = 8'(16 + 2*N);
    bus_read(16, r); check("R10 past table reads 0", r, 32'h0);
    check("R10 sticky", 32'(err_flag), 32'h1);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  s = 8'($urandom_range(0, 16 + 2*N + 4));
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom();
      bus_write(0, {24'h0, s}); sel_m = s;
      if ($urandom_range(0, 1) == 1) begin
        bus_write(16, d); model_data_write(d);
      end
      bus_read(16, r);
      if (!defined_idx(s)) err_m = 1'b1;
      check(defined_idx(s) ? "R7 random readback" : "R10 undefined reads 0", r, model_read(s));
    end
    check("R10 final flag", 32'(err_flag), 32'(err_m));
    check("R4 final id", 32'(id_out), 32'(id_m));
    check("R6 final arb", 32'(arb_out), 32'(arb_m));
    check_fields();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule